// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sequences the two control-flow events of a 16-bit processor core with eight general registers: taking an interrupt and returning from one. It owns the processor status word. That word holds a privilege bit, a three-bit priority level and the three condition flags. The block also keeps the saved stack pointers for user mode and supervisor mode. The core tells it when an instruction has fully finished, which is after the result has been stored. Only then may a pending interrupt be accepted. The core also tells it when a return-from-interrupt instruction has been decoded.

On entry, the block moves to the supervisor stack if the core was in user mode. It then pushes the status word, followed by the interrupted program counter. It switches to supervisor mode at the new priority, fetches the handler address from a vector table and hands the new PC and stack pointer back to the core.

On return, it pops the PC and then the status word. If the popped status says user mode, it parks the supervisor stack pointer and gives the core back the saved user stack pointer. A return attempted in user mode is refused with a one-cycle fault flag. While a sequence runs, `busy` is high and the core stalls. Memory is reached through a single-port request/acknowledge handshake.

Top module: `intr_seq`

## Requirements
- R1: After reset the status word reads 0x8000, `busy` is low, `mem_req` is low and `priv_fault` is low. In the status word, bit 15 is privilege (1 = user, 0 = supervisor), bits 10:8 are the priority level and bits 2:0 are the N, Z and P flags; every other bit reads 0.
- R2: When `cc_we` is high while the block is idle, `cc_in` is loaded into status bits 2:0 on the next clock edge, and no other status bit changes.
- R3: An interrupt is accepted only in a cycle where `at_boundary`, `irq_req` and `irq_prio` greater than the current priority level all hold. The comparison is strict. In every other case `busy` and `mem_req` stay low.
- R4: On entry from user mode, the incoming `sp_in` is saved as the user stack pointer and the saved supervisor stack pointer is used (SSP_RESET after reset). On entry from supervisor mode, `sp_in` itself is used.
- R5: Entry pushes by first decrementing and then writing. The status word as it was before entry goes to stack pointer minus 1, and `pc_in` goes to stack pointer minus 2.
- R6: Entry then reads the vector table at address {VEC_BASE[15:8], `irq_vec`}. It loads the value read into the PC through `pc_we`/`pc_out`, and writes the final stack pointer (stack pointer minus 2) through `sp_we`/`sp_out`.
- R7: After entry, the privilege bit is 0, the priority level equals the accepted `irq_prio`, and the flags are unchanged.
- R8: A return in supervisor mode pops by reading and then incrementing. The PC is read at `sp_in` and the status word at `sp_in`+1. The PC and the status word, restricted to its three fields, are loaded.
- R9: If the popped privilege bit is 1, the stack pointer after the two pops is saved as the supervisor pointer and the core receives the saved user pointer. Otherwise the core receives `sp_in`+2.
- R10: A return requested in user mode raises `priv_fault` for that cycle only. It makes no memory access and changes neither the status word nor the stack pointer.
- R11: When an acceptable interrupt and a return request arrive in the same cycle, the interrupt is taken.
- R12: While `mem_req` is high and `mem_ack` is low, the request, its direction and its address stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| at_boundary | input | 1 | Current instruction has finished its store-result phase |
| irq_req | input | 1 | Interrupt request |
| irq_prio | input | 3 | Priority of the request |
| irq_vec | input | 8 | Vector number of the request |
| rti_go | input | 1 | Return-from-interrupt instruction decoded |
| cc_we | input | 1 | Condition flag update strobe |
| cc_in | input | 3 | New N, Z, P flags |
| pc_in | input | 16 | Address of the next instruction |
| pc_out | output | 16 | New PC value |
| pc_we | output | 1 | Load strobe for the core PC |
| sp_in | input | 16 | Current stack-pointer register value |
| sp_out | output | 16 | New stack-pointer register value |
| sp_we | output | 1 | Write strobe for the stack-pointer register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |
| busy | output | 1 | A sequence is running |
| priv_fault | output | 1 | Return refused in user mode |
| psr_out | output | 16 | Current status word |

## Verification
The embedded properties check the following on every cycle: the memory handshake stays stable until acknowledged, an entry sequence starts only from an accepted request at an instruction boundary, a completed entry leaves supervisor mode at a strictly higher priority, a refused return leaves the block idle with the status untouched, and an interrupt wins over a simultaneous return. Only the bench scenarios can show where the words land on the stack, what the vector table lookup returns, and the values the stack pointer takes across a nested entry and a two-level unwinding. The same holds for the supervisor pointer surviving a full round trip through user mode.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int PL_W     = 3;
  localparam int CC_W     = 3;
  localparam int PRIV_BIT = 15;
  localparam int PL_LO    = 8;
  localparam int CC_LO    = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENT_PSR,
    ST_ENT_PC,
    ST_ENT_VEC,
    ST_RET_PC,
    ST_RET_PSR
  } seq_state_t;
endpackage

// File: rtl/intr_accept.sv
module intr_accept
  import intr_pkg::*;
(
  input  logic            idle,
  input  logic            at_boundary,
  input  logic            irq_req,
  input  logic [PL_W-1:0] irq_prio,
  input  logic            rti_go,
  input  logic            cur_priv,
  input  logic [PL_W-1:0] cur_pl,
  output logic            take,
  output logic            ret_go,
  output logic            fault
);
  logic outranks;

  always_comb begin
    outranks = irq_prio > cur_pl;
    take     = idle && at_boundary && irq_req && outranks;
    ret_go   = idle && rti_go && !take && !cur_priv;
    fault    = idle && rti_go && !take && cur_priv;
  end
endmodule

// File: rtl/intr_psr.sv
module intr_psr
  import intr_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cc_we,
  input  logic [CC_W-1:0] cc_in,
  input  logic            ent_we,
  input  logic [PL_W-1:0] ent_pl,
  input  logic            ret_we,
  input  logic            ret_priv,
  input  logic [PL_W-1:0] ret_pl,
  input  logic [CC_W-1:0] ret_cc,
  output logic            priv,
  output logic [PL_W-1:0] pl,
  output logic [XLEN-1:0] psr_word
);
  logic            priv_d;
  logic [PL_W-1:0] pl_d;
  logic [CC_W-1:0] cc_q, cc_d;
  logic            upd_en;

  always_comb begin
    priv_d = priv;
    pl_d   = pl;
    cc_d   = cc_q;
    upd_en = ret_we || ent_we || cc_we;
    if (ret_we) begin
      priv_d = ret_priv;
      pl_d   = ret_pl;
      cc_d   = ret_cc;
    end else if (ent_we) begin
      priv_d = 1'b0;
      pl_d   = ent_pl;
    end else if (cc_we) begin
      cc_d = cc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv <= 1'b1;
      pl   <= '0;
      cc_q <= '0;
    end else if (upd_en) begin
      priv <= priv_d;
      pl   <= pl_d;
      cc_q <= cc_d;
    end
  end

  always_comb begin
    psr_word                 = '0;
    psr_word[PRIV_BIT]       = priv;
    psr_word[PL_LO +: PL_W]  = pl;
    psr_word[CC_LO +: CC_W]  = cc_q;
  end

  // R2: a lone flag update lands in the flag field on the next edge
  assert_flag_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && !ent_we && !ret_we) |=> (psr_word[CC_LO +: CC_W] == $past(cc_in)) && $stable(priv));
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int              XLEN      = 16,
  parameter int              VEC_W     = 8,
  parameter logic [XLEN-1:0] VEC_BASE  = 16'h0100,
  parameter logic [XLEN-1:0] SSP_RESET = 16'h3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             ret_go,
  input  logic [PL_W-1:0]  irq_prio,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             cur_priv,
  input  logic [XLEN-1:0]  psr_word,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ack,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [XLEN-1:0]  pc_out,
  output logic             pc_we,
  output logic [XLEN-1:0]  sp_out,
  output logic             sp_we,
  output logic             ent_we,
  output logic [PL_W-1:0]  ent_pl,
  output logic             ret_we,
  output logic             ret_priv,
  output logic [PL_W-1:0]  ret_pl,
  output logic [CC_W-1:0]  ret_cc
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  seq_state_t       state, state_d;
  logic [XLEN-1:0]  work_sp, work_sp_d;
  logic [XLEN-1:0]  hold_psr, hold_pc;
  logic [VEC_W-1:0] hold_vec;
  logic [PL_W-1:0]  hold_prio;
  logic [XLEN-1:0]  usp_save, ssp_save;
  logic [XLEN-1:0]  vec_addr, sp_inc;
  logic             hold_en, hpc_en, usp_en, ssp_en;

  always_comb begin
    vec_addr = {VEC_BASE[XLEN-1:VEC_W], hold_vec};
    sp_inc   = work_sp + ONE;
  end

  always_comb begin
    state_d   = state;
    work_sp_d = work_sp;
    hold_en   = 1'b0;
    hpc_en    = 1'b0;
    usp_en    = 1'b0;
    ssp_en    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = work_sp;
    mem_wdata = '0;
    pc_out    = '0;
    pc_we     = 1'b0;
    sp_out    = '0;
    sp_we     = 1'b0;
    ent_we    = 1'b0;
    ret_we    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (take) begin
          state_d   = ST_ENT_PSR;
          work_sp_d = (cur_priv ? ssp_save : sp_in) - ONE;
          hold_en   = 1'b1;
          usp_en    = cur_priv;
        end else if (ret_go) begin
          state_d   = ST_RET_PC;
          work_sp_d = sp_in;
        end
      end
      ST_ENT_PSR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = hold_psr;
        if (mem_ack) begin
          work_sp_d = work_sp - ONE;
          state_d   = ST_ENT_PC;
        end
      end
      ST_ENT_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = hold_pc;
        if (mem_ack) state_d = ST_ENT_VEC;
      end
      ST_ENT_VEC: begin
        mem_req  = 1'b1;
        mem_addr = vec_addr;
        if (mem_ack) begin
          pc_we   = 1'b1;
          pc_out  = mem_rdata;
          sp_we   = 1'b1;
          sp_out  = work_sp;
          ent_we  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RET_PC: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          hpc_en    = 1'b1;
          work_sp_d = sp_inc;
          state_d   = ST_RET_PSR;
        end
      end
      ST_RET_PSR: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          pc_we   = 1'b1;
          pc_out  = hold_pc;
          ret_we  = 1'b1;
          sp_we   = 1'b1;
          if (mem_rdata[PRIV_BIT]) begin
            ssp_en = 1'b1;
            sp_out = usp_save;
          end else begin
            sp_out = sp_inc;
          end
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      work_sp <= '0;
    end else begin
      state   <= state_d;
      work_sp <= work_sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_psr  <= '0;
      hold_vec  <= '0;
      hold_prio <= '0;
    end else if (hold_en) begin
      hold_psr  <= psr_word;
      hold_vec  <= irq_vec;
      hold_prio <= irq_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_pc <= '0;
    else if (hold_en) hold_pc <= pc_in;
    else if (hpc_en)  hold_pc <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      usp_save <= '0;
    else if (usp_en) usp_save <= sp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ssp_save <= SSP_RESET;
    else if (ssp_en) ssp_save <= sp_inc;
  end

  always_comb begin
    busy     = state != ST_IDLE;
    ent_pl   = hold_prio;
    ret_priv = mem_rdata[PRIV_BIT];
    ret_pl   = mem_rdata[PL_LO +: PL_W];
    ret_cc   = mem_rdata[CC_LO +: CC_W];
  end

  // R12: an unacknowledged request keeps its direction and address
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_pkg::*;
#(
  parameter int              XLEN      = 16,
  parameter int              VEC_W     = 8,
  parameter logic [XLEN-1:0] VEC_BASE  = 16'h0100,
  parameter logic [XLEN-1:0] SSP_RESET = 16'h3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             at_boundary,
  input  logic             irq_req,
  input  logic [PL_W-1:0]  irq_prio,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             rti_go,
  input  logic             cc_we,
  input  logic [CC_W-1:0]  cc_in,
  input  logic [XLEN-1:0]  pc_in,
  output logic [XLEN-1:0]  pc_out,
  output logic             pc_we,
  input  logic [XLEN-1:0]  sp_in,
  output logic [XLEN-1:0]  sp_out,
  output logic             sp_we,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ack,
  output logic             busy,
  output logic             priv_fault,
  output logic [XLEN-1:0]  psr_out
);
  logic            rst_meta, rst_sync;
  logic            priv, take, ret_go, ent_we, ret_we, ret_priv, cc_we_idle;
  logic [PL_W-1:0] pl, ent_pl, ret_pl;
  logic [CC_W-1:0] ret_cc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign cc_we_idle = cc_we && !busy;

  intr_accept u_accept (
    .idle        (!busy),
    .at_boundary (at_boundary),
    .irq_req     (irq_req),
    .irq_prio    (irq_prio),
    .rti_go      (rti_go),
    .cur_priv    (priv),
    .cur_pl      (pl),
    .take        (take),
    .ret_go      (ret_go),
    .fault       (priv_fault)
  );

  intr_psr #(.XLEN(XLEN)) u_psr (
    .clk      (clk),
    .rst_n    (rst_sync),
    .cc_we    (cc_we_idle),
    .cc_in    (cc_in),
    .ent_we   (ent_we),
    .ent_pl   (ent_pl),
    .ret_we   (ret_we),
    .ret_priv (ret_priv),
    .ret_pl   (ret_pl),
    .ret_cc   (ret_cc),
    .priv     (priv),
    .pl       (pl),
    .psr_word (psr_out)
  );

  intr_ctrl #(
    .XLEN(XLEN), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .SSP_RESET(SSP_RESET)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .take      (take),
    .ret_go    (ret_go),
    .irq_prio  (irq_prio),
    .irq_vec   (irq_vec),
    .cur_priv  (priv),
    .psr_word  (psr_out),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_out    (pc_out),
    .pc_we     (pc_we),
    .sp_out    (sp_out),
    .sp_we     (sp_we),
    .ent_we    (ent_we),
    .ent_pl    (ent_pl),
    .ret_we    (ret_we),
    .ret_priv  (ret_priv),
    .ret_pl    (ret_pl),
    .ret_cc    (ret_cc)
  );

  // R3: an entry (first access is a write) starts only from a request at a boundary
  assert_entry_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy && !$past(busy) && mem_we) |-> $past(at_boundary && irq_req));

  // R7: a finished entry leaves supervisor mode at a strictly higher level
  assert_entry_raises_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    ent_we |=> !priv && (pl > $past(pl)));

  // R10: a refused return leaves the block idle and the status word untouched
  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    priv_fault |=> !busy && $stable(psr_out));

  // R11: an acceptable request beats a simultaneous return request
  assert_irq_first_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    (!busy && at_boundary && irq_req && rti_go && (irq_prio > pl)) |=> busy && mem_we);
endmodule

// File: tb/intr_seq_bench.sv
`timescale 1ns/1ps
module intr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        at_boundary = 1'b0, irq_req = 1'b0, rti_go = 1'b0, cc_we = 1'b0;
  logic [2:0]  irq_prio = '0, cc_in = '0;
  logic [7:0]  irq_vec = '0;
  logic [15:0] pc_out, sp_out, mem_addr, mem_wdata, psr_out;
  logic [15:0] mem_rdata = '0;
  logic        pc_we, sp_we, mem_req, mem_we, busy, priv_fault;
  logic        mem_ack = 1'b0;

  logic [15:0] core_pc = '0, core_sp = '0;
  logic [15:0] mem [4096];
  logic [15:0] model_psr = 16'h8000;
  logic        mon_on = 1'b0;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intr_seq u_intr_seq (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
    .irq_prio(irq_prio), .irq_vec(irq_vec), .rti_go(rti_go), .cc_we(cc_we),
    .cc_in(cc_in), .pc_in(core_pc), .pc_out(pc_out), .pc_we(pc_we),
    .sp_in(core_sp), .sp_out(sp_out), .sp_we(sp_we), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
    .priv_fault(priv_fault), .psr_out(psr_out)
  );

  // core registers written by the block's strobes
  always @(posedge clk) begin
    if (pc_we) core_pc <= pc_out;
    if (sp_we) core_sp <= sp_out;
  end

  // memory: acknowledges every access one cycle after it is seen
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference status and idle behaviour
  always @(negedge clk) begin
    if (mon_on && !busy) begin
      chk("R1/R2 status vs model", psr_out, model_psr);
      chk("R3 no access while idle", {15'd0, mem_req}, 16'd0);
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 50 && busy; i++) tick();
  endtask

  task automatic raise_irq(input logic [2:0] p, input logic [7:0] v);
    at_boundary = 1'b1; irq_req = 1'b1; irq_prio = p; irq_vec = v;
    tick();
    at_boundary = 1'b0; irq_req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h142] = 16'h1200;
    mem[12'h110] = 16'h1400;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 reset status", psr_out, 16'h8000);
    chk("R1 reset busy", {15'd0, busy}, 16'd0);
    chk("R1 reset mem_req", {15'd0, mem_req}, 16'd0);
    chk("R1 reset fault", {15'd0, priv_fault}, 16'd0);
    mon_on = 1'b1;

    // R2: flag update
    cc_we = 1'b1; cc_in = 3'b010;
    tick();
    cc_we = 1'b0; model_psr = 16'h8002;
    chk("R2 flags loaded", psr_out, 16'h8002);

    core_sp = 16'h5000; core_pc = 16'h3010;

    // R3: request without boundary is ignored
    irq_req = 1'b1; irq_prio = 3'd3; irq_vec = 8'h42;
    repeat (3) tick();
    chk("R3 no boundary not taken", {15'd0, busy}, 16'd0);
    // R3: equal priority is not enough
    at_boundary = 1'b1; irq_prio = 3'd0;
    repeat (2) tick();
    chk("R3 equal level not taken", {15'd0, busy}, 16'd0);
    at_boundary = 1'b0; irq_req = 1'b0;

    // R4 R5 R6 R7: entry from user mode
    raise_irq(3'd3, 8'h42);
    chk("R3 accepted", {15'd0, busy}, 16'd1);
    wait_idle();
    model_psr = 16'h0302;
    chk("R5 status pushed", mem[12'hFFF], 16'h8002);
    chk("R5 pc pushed", mem[12'hFFE], 16'h3010);
    chk("R6 vector loaded", core_pc, 16'h1200);
    chk("R4 supervisor stack used", core_sp, 16'h2FFE);
    chk("R7 entry status", psr_out, 16'h0302);

    // R3: nested request at current level refused
    core_pc = 16'h1208;
    at_boundary = 1'b1; irq_req = 1'b1; irq_prio = 3'd3;
    repeat (2) tick();
    chk("R3 nested equal refused", {15'd0, busy}, 16'd0);
    at_boundary = 1'b0; irq_req = 1'b0;

    // R4 R5: nested entry from supervisor mode
    raise_irq(3'd5, 8'h10);
    wait_idle();
    model_psr = 16'h0502;
    chk("R5 nested status pushed", mem[12'hFFD], 16'h0302);
    chk("R5 nested pc pushed", mem[12'hFFC], 16'h1208);
    chk("R6 nested vector", core_pc, 16'h1400);
    chk("R4 nested keeps stack", core_sp, 16'h2FFC);
    chk("R7 nested level", psr_out, 16'h0502);

    // R8 R9: return to supervisor
    rti_go = 1'b1; tick(); rti_go = 1'b0;
    wait_idle();
    model_psr = 16'h0302;
    chk("R8 pc popped", core_pc, 16'h1208);
    chk("R8 status popped", psr_out, 16'h0302);
    chk("R9 supervisor stack", core_sp, 16'h2FFE);

    // R8 R9: return to user
    rti_go = 1'b1; tick(); rti_go = 1'b0;
    wait_idle();
    model_psr = 16'h8002;
    chk("R8 pc popped user", core_pc, 16'h3010);
    chk("R8 status popped user", psr_out, 16'h8002);
    chk("R9 user stack restored", core_sp, 16'h5000);

    // R10: return in user mode
    rti_go = 1'b1; #1;
    chk("R10 fault raised", {15'd0, priv_fault}, 16'd1);
    chk("R10 no access", {15'd0, mem_req}, 16'd0);
    tick(); rti_go = 1'b0; #1;
    chk("R10 fault one cycle", {15'd0, priv_fault}, 16'd0);
    chk("R10 not busy", {15'd0, busy}, 16'd0);
    chk("R10 stack untouched", core_sp, 16'h5000);

    // R11 R4: simultaneous return and request; supervisor pointer reused
    mem[12'hFFF] = '0; mem[12'hFFE] = '0;
    rti_go = 1'b1; at_boundary = 1'b1; irq_req = 1'b1; irq_prio = 3'd2; irq_vec = 8'h42;
    #1;
    chk("R11 no fault", {15'd0, priv_fault}, 16'd0);
    tick();
    rti_go = 1'b0; at_boundary = 1'b0; irq_req = 1'b0;
    chk("R11 entry taken", {15'd0, busy & mem_we}, 16'd1);
    wait_idle();
    model_psr = 16'h0202;
    chk("R4 saved supervisor pointer", core_sp, 16'h2FFE);
    chk("R5 status pushed again", mem[12'hFFF], 16'h8002);
    chk("R5 pc pushed again", mem[12'hFFE], 16'h3010);
    chk("R7 level 2", psr_out, 16'h0202);

    // R2: flags change under supervisor mode, other fields kept
    cc_we = 1'b1; cc_in = 3'b100;
    tick();
    cc_we = 1'b0; model_psr = 16'h0204;
    chk("R2 flags in supervisor", psr_out, 16'h0204);

    repeat (2) tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule